// File: doc/BRIEF.md
# Raster Beam Position Counter with Position Interrupts

This block stands in for the electron beam of a 60 Hz raster display so that game code can follow the beam's vertical position and be interrupted at fixed points on the screen. A 14-bit counter advances once per CPU cycle. It represents a 16-bit video address, which is the count shifted left by two. Two interrupt request lines are decoded from that video address. The CPU can also sample the upper six address bits through a read strobe.

Each frame holds two passes of the counter. On the first overflow of a frame the counter does not wrap to zero. It jumps to a reload value near the top of its range, so the frame is stretched to about 16.6 ms at 1 MHz. On the second overflow the counter wraps to zero and the next frame begins. Both request lines stay asserted for hundreds of cycles. A CPU that samples interrupts only at instruction boundaries therefore cannot miss them.

Top module: `beam_counter`

## Requirements
- R1: While reset is asserted and right after it is released, the counter is zero, the frame-phase flag is clear, both interrupt requests are low and the readback value is 0.
- R2: Starting from zero, the counter advances by exactly one on every clock, so the readback field (video address bits 15..10, which are count bits 13..8) holds each value for 256 cycles.
- R3: The first time a frame's count reaches all ones, the next count is 16128 (0x3F00), which keeps the readback value at 0x3F for 512 consecutive cycles.
- R4: The second time a frame's count reaches all ones, the count wraps to zero, so one frame lasts 16384 + 256 = 16640 cycles.
- R5: The periodic request `irq_periodic` equals bit 11 of the video address (count bit 9).
- R6: The screen-end request `irq_screen_end` is high exactly while bits 14..11 of the video address (count bits 12..9) are all ones.
- R7: Every high pulse on either request line lasts at least 100 cycles.
- R8: On a clock edge where `rd_stb` is high, `rd_data` takes video address bits 15..10 of the count as it stood before that edge; on all other edges it holds its value.
- R9: Reading has no side effects: the count and both request lines evolve the same way whatever `rd_stb` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Readback register read strobe |
| rd_data | output | 6 | Upper six video address bits captured at the last strobe |
| irq_periodic | output | 1 | Periodic interrupt request from video address bit 11 |
| irq_screen_end | output | 1 | Request asserted while video address bits 14..11 are all set |

## Verification
The bench builds the block with its default parameters: a 14-bit counter, a shift of two and a reload value of 16128. With these values the run covers three full 16640-cycle frames. Every frame goes through both the reload overflow and the wrap overflow, and every pulse pattern of the two request lines appears. For the first two frames the strobe is held high, so run lengths of the readback field expose the step rate, the reload window and the frame length. In the last frame the strobe is sparse, which shows that reads change neither the count nor the request lines.

// File: rtl/beam_counter.sv
module beam_counter #(
  parameter int CNT_W   = 14,
  parameter int SHIFT   = 2,
  parameter int RELOAD  = 16128,
  parameter int PER_BIT = 11,
  parameter int EOS_HI  = 14,
  parameter int EOS_LO  = 11,
  parameter int RD_W    = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  output logic [RD_W-1:0] rd_data,
  output logic            irq_periodic,
  output logic            irq_screen_end
);
  localparam int VA_W = CNT_W + SHIFT;

  logic [CNT_W-1:0] cnt;
  logic             late;
  logic [VA_W-1:0]  vaddr;
  logic             at_top;

  assign vaddr  = {cnt, {SHIFT{1'b0}}};
  assign at_top = &cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      late <= 1'b0;
    end else if (at_top) begin
      late <= ~late;
      cnt  <= late ? '0 : CNT_W'(RELOAD);
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= vaddr[VA_W-1 -: RD_W];
  end

  assign irq_periodic   = vaddr[PER_BIT];
  assign irq_screen_end = &vaddr[EOS_HI:EOS_LO];

  AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !at_top |=> cnt == $past(cnt) + 1'b1); // R2
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !late) |=> (cnt == CNT_W'(RELOAD)) && late); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && late) |=> (cnt == '0) && !late); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data)); // R8
  AST_EOS_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (at_top && !late) |=> irq_screen_end); // R6
endmodule

// File: tb/beam_counter_tb.sv
module beam_counter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0;
  logic [5:0] rd_data;
  logic       irq_periodic, irq_screen_end;

  always #2.5 clk = ~clk;

  beam_counter u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
    .rd_data(rd_data), .irq_periodic(irq_periodic), .irq_screen_end(irq_screen_end)
  );

  int vectors = 0;
  int miscompares = 0;
  int m_cnt = 0;
  bit m_late = 1'b0;
  int m_rd = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit all_strobe = 1'b0;

  function automatic int va(input int c);
    return c * 4;
  endfunction

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst_n) begin
      m_cnt = 0; m_late = 1'b0; m_rd = 0;
    end else begin
      if (rd_stb) m_rd = (va(m_cnt) >> 10) & 63;
      if (m_cnt == 16383) begin
        m_cnt = m_late ? 0 : 16128;
        m_late = ~m_late;
      end else m_cnt = m_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  int prev_rd = 0, run_rd = 0, last_wrap = -1;
  int per_run = 0, eos_run = 0;
  bit prev_per = 1'b0, prev_eos = 1'b0, seen_wrap = 1'b0;

  always @(negedge clk) begin
    if (!done) begin
      int e_per, e_eos;
      e_per = (va(m_cnt) >> 11) & 1;
      e_eos = (((va(m_cnt) >> 11) & 15) == 15) ? 1 : 0;
      if (!rst_n) begin
        check(rd_data == 6'd0 && !irq_periodic && !irq_screen_end, "R1",
              {rd_data, irq_periodic, irq_screen_end}, 0);
      end else begin
        check(int'(irq_periodic) == e_per, rd_stb ? "R5/R9" : "R5", irq_periodic, e_per);
        check(int'(irq_screen_end) == e_eos, rd_stb ? "R6/R9" : "R6", irq_screen_end, e_eos);
        check(int'(rd_data) == m_rd, "R8", rd_data, m_rd);
        if (irq_periodic) per_run++;
        else begin
          if (prev_per) check(per_run >= 100, "R7", per_run, 100);
          per_run = 0;
        end
        if (irq_screen_end) eos_run++;
        else begin
          if (prev_eos) check(eos_run >= 100, "R7", eos_run, 100);
          eos_run = 0;
        end
        prev_per = irq_periodic; prev_eos = irq_screen_end;
        if (all_strobe) begin
          if (int'(rd_data) != prev_rd) begin
            if (prev_rd == 63 && rd_data == 6'd0) begin
              check(run_rd == 512, "R3", run_rd, 512);
              if (last_wrap >= 0) check(cyc - last_wrap == 16640, "R4", cyc - last_wrap, 16640);
              last_wrap = cyc;
              seen_wrap = 1'b1;
            end else if (prev_rd == 0 && seen_wrap) begin
              check(run_rd == 256, "R2", run_rd, 256);
            end
            run_rd = 1;
          end else run_rd++;
          prev_rd = rd_data;
        end
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    rd_stb = 1'b1;
    all_strobe = 1'b1;
    repeat (2 * 16640 + 300) @(negedge clk);
    all_strobe = 1'b0;
    for (int i = 0; i < 16640 + 500; i++) begin
      rd_stb = (i % 7 == 3) || (i % 311 == 0);
      @(negedge clk);
    end
    rd_stb = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog at cycle %0d: actual running expected finished", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule